// File: doc/BRIEF.md
# Hybrid Recursive Carry-Lookahead Adder

This block is a purely combinational two-operand adder, 32 bits wide by default, with a carry input and a carry output. Each bit first forms a propagate term (XOR of the operand bits) and a generate term (AND of the operand bits). Lookahead groups then turn these terms into carries. Within a group, every carry is written as an explicit sum of products that starts from the group's single carry input. The carries do not ripple from bit to bit inside a group. Only the top carry of each group leaves it, and it becomes the carry input of the next group up.

In hybrid mode, the lowest nibble is not a 4-bit lookahead group. Bits 0 and 1 are two ripple full-adder carry cells fed by the external carry input. Bits 2 and 3 form a reduced 2-bit lookahead group, and its carry input is the ripple carry out of bit 1. This keeps the deep four-wide product terms off the path that starts at the operand inputs. A parameter selects homogeneous mode instead, which uses uniform 4-bit groups all the way down. Both modes give bit-exact results. The block is used as an arithmetic leaf wherever a fast single-cycle add is needed.

Top module: `hybrid_cla_adder`

## Requirements
- R1: {carry_out, sum_out} equals op_a + op_b + carry_in exactly, as a 33-bit unsigned result, for every input combination.
- R2: For each bit, propagate is op_a XOR op_b and generate is op_a AND op_b. Each sum bit is that bit's propagate XOR the carry entering that bit.
- R3: Inside every lookahead group, the carry out of each bit equals generate OR (propagate AND the carry into that bit). That carry is formed directly from the group carry-in and the group's propagate/generate terms.
- R4: A carry generated in one 4-bit group reaches the next group only through that group's most significant carry. For example, 0x0000000F + 0x00000001 = 0x00000010, and 0x0FFFFFFF + 0x00000001 = 0x10000000.
- R5: In hybrid mode (HYBRID=1), bits 0 and 1 are ripple carry cells fed by carry_in, and bits 2 to 3 form a 2-bit lookahead group fed by the carry out of bit 1. For example, 0x3 + 0x1 = 0x4, and 0x1 + 0x0 with carry_in=1 gives 0x2.
- R6: In homogeneous mode (HYBRID=0), the block uses WIDTH/GROUP uniform 4-bit groups and produces the same results as hybrid mode for the same inputs.
- R7: carry_out is the carry out of bit WIDTH-1. The all-ones operand plus zero with carry_in=1 gives sum 0 and carry_out 1. All-ones plus all-ones with carry_in=1 gives an all-ones sum and carry_out 1.
- R8: All-zero operands with carry_in=0 give a zero sum and carry_out 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | WIDTH (32) | First operand |
| op_b | input | WIDTH (32) | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum_out | output | WIDTH (32) | Sum bits |
| carry_out | output | 1 | Carry out of the most significant bit |

## Verification
The checker assertions take for granted that op_a, op_b and carry_in are two-state values that have settled, because the block has no clock and every check compares settled combinational values. The bench changes the inputs only on the falling edge of its clock and compares the outputs on the rising edge, half a period later, so no check sees a partial update. The stimulus uses only fully defined values: fixed corner patterns, then seeded random operands with a random carry_in. Both the hybrid and the homogeneous instance receive exactly the same values.

// File: rtl/hcla_pkg.sv
package hcla_pkg;

    // Per-bit carry terms
    typedef struct packed {
        logic p;   // propagate
        logic g;   // generate
    } pg_t;

    // Number of ripple cells that replace the bottom of the lowest group
    localparam int RIPPLE_BITS = 2;

    function automatic pg_t make_pg(input logic x, input logic y);
        pg_t r;
        r.p = x ^ y;
        r.g = x & y;
        return r;
    endfunction

    function automatic logic ripple_carry(input pg_t v, input logic c);
        return v.g | (v.p & c);
    endfunction

endpackage

// File: rtl/hcla_pg.sv
module hcla_pg
    import hcla_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0]      op_a,
    input  logic [WIDTH-1:0]      op_b,
    output pg_t  [WIDTH-1:0]      pg
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        assign pg[b] = make_pg(op_a[b], op_b[b]);
    end
endmodule

// File: rtl/hcla_ripple_cell.sv
module hcla_ripple_cell
    import hcla_pkg::*;
(
    input  pg_t  pg,
    input  logic cin,
    output logic cout
);
    assign cout = ripple_carry(pg, cin);
endmodule

// File: rtl/hcla_lcg.sv
// Lookahead carry generator: every carry is a flat sum of products
// rooted at the single group carry-in.
module hcla_lcg
    import hcla_pkg::*;
#(
    parameter int M = 4
) (
    input  pg_t  [M-1:0] pg,
    input  logic         cin,
    output logic [M-1:0] cout
);
    always_comb begin
        for (int i = 0; i < M; i++) begin
            logic carry;
            logic term;
            // carry-in term through all propagates up to bit i
            term = cin;
            for (int k = 0; k <= i; k++) begin
                term = term & pg[k].p;
            end
            carry = term;
            // generate at bit j, propagated through bits j+1..i
            for (int j = 0; j <= i; j++) begin
                term = pg[j].g;
                for (int k = j + 1; k <= i; k++) begin
                    term = term & pg[k].p;
                end
                carry = carry | term;
            end
            cout[i] = carry;
        end
    end
endmodule

// File: rtl/hybrid_cla_adder.sv
module hybrid_cla_adder
    import hcla_pkg::*;
#(
    parameter int WIDTH  = 32,
    parameter int GROUP  = 4,
    parameter bit HYBRID = 1'b1
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             carry_in,
    output logic [WIDTH-1:0] sum_out,
    output logic             carry_out
);
    localparam int NGROUP     = WIDTH / GROUP;
    localparam int LOW_RIPPLE = HYBRID ? RIPPLE_BITS : 0;
    localparam int LOW_LA     = GROUP - LOW_RIPPLE;

    pg_t  [WIDTH-1:0] pg;
    logic [WIDTH:0]   cvec;   // cvec[b] = carry entering bit b
    logic [WIDTH-1:0] pv;
    logic [WIDTH-1:0] gv;

    hcla_pg #(.WIDTH(WIDTH)) u_pg (
        .op_a (op_a),
        .op_b (op_b),
        .pg   (pg)
    );

    assign cvec[0] = carry_in;

    // Lowest group: optional ripple cells then a reduced lookahead group
    if (LOW_RIPPLE > 0) begin : g_ripple
        for (genvar r = 0; r < LOW_RIPPLE; r++) begin : g_cell
            hcla_ripple_cell u_cell (
                .pg   (pg[r]),
                .cin  (cvec[r]),
                .cout (cvec[r+1])
            );
        end
    end

    hcla_lcg #(.M(LOW_LA)) u_lcg_low (
        .pg   (pg[LOW_RIPPLE +: LOW_LA]),
        .cin  (cvec[LOW_RIPPLE]),
        .cout (cvec[LOW_RIPPLE+1 +: LOW_LA])
    );

    // Upper groups, each fed only by the top carry of the group below
    for (genvar k = 1; k < NGROUP; k++) begin : g_grp
        hcla_lcg #(.M(GROUP)) u_lcg (
            .pg   (pg[k*GROUP +: GROUP]),
            .cin  (cvec[k*GROUP]),
            .cout (cvec[k*GROUP+1 +: GROUP])
        );
    end

    // Sum logic
    for (genvar b = 0; b < WIDTH; b++) begin : g_sum
        assign pv[b]      = pg[b].p;
        assign gv[b]      = pg[b].g;
        assign sum_out[b] = pg[b].p ^ cvec[b];
    end

    assign carry_out = cvec[WIDTH];
endmodule

// File: rtl/hybrid_cla_chk.sv
module hybrid_cla_chk #(
    parameter int WIDTH = 32
) (
    input logic [WIDTH-1:0] op_a,
    input logic [WIDTH-1:0] op_b,
    input logic             carry_in,
    input logic [WIDTH-1:0] sum_out,
    input logic             carry_out,
    input logic [WIDTH:0]   cvec,
    input logic [WIDTH-1:0] pv,
    input logic [WIDTH-1:0] gv
);
    logic [WIDTH:0] ref_total;
    assign ref_total = {1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in};

    always_comb begin
        a_r1_exact_sum: assert ({carry_out, sum_out} == ref_total)
            else $error("R1 sum mismatch");
        a_r2_pg_terms: assert (pv == (op_a ^ op_b) && gv == (op_a & op_b))
            else $error("R2 propagate/generate mismatch");
        a_r2_sum_bits: assert (sum_out == (pv ^ cvec[WIDTH-1:0]))
            else $error("R2 sum bit mismatch");
        a_r5_entry_carry: assert (cvec[0] == carry_in)
            else $error("R5 entry carry mismatch");
        a_r7_carry_out: assert (carry_out == cvec[WIDTH])
            else $error("R7 carry out mismatch");
        for (int i = 0; i < WIDTH; i++) begin
            a_r3_carry_recur: assert (cvec[i+1] == (gv[i] | (pv[i] & cvec[i])))
                else $error("R3 carry relation broken");
        end
    end
endmodule

bind hybrid_cla_adder hybrid_cla_chk #(.WIDTH(WIDTH)) u_chk (
    .op_a      (op_a),
    .op_b      (op_b),
    .carry_in  (carry_in),
    .sum_out   (sum_out),
    .carry_out (carry_out),
    .cvec      (cvec),
    .pv        (pv),
    .gv        (gv)
);

// File: tb/hybrid_cla_adder_tb.sv
module hybrid_cla_adder_tb;
    localparam int W = 32;

    typedef struct {
        logic [W:0] exp;
        string      tag;
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic       c;
    } item_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;   // 50 MHz

    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic         carry_in = 1'b0;
    logic [W-1:0] sum_h, sum_u;
    logic         co_h, co_u;

    hybrid_cla_adder #(.WIDTH(W), .GROUP(4), .HYBRID(1'b1)) u_dut (
        .op_a (op_a), .op_b (op_b), .carry_in (carry_in),
        .sum_out (sum_h), .carry_out (co_h)
    );

    hybrid_cla_adder #(.WIDTH(W), .GROUP(4), .HYBRID(1'b0)) u_dut_homog (
        .op_a (op_a), .op_b (op_b), .carry_in (carry_in),
        .sum_out (sum_u), .carry_out (co_u)
    );

    item_t q[$];
    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic c, input string tag);
        item_t it;
        @(negedge clk);
        op_a = a; op_b = b; carry_in = c;
        it.exp = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, c};
        it.tag = tag; it.a = a; it.b = b; it.c = c;
        q.push_back(it);
    endtask

    // Monitor: compare both modes against the reference at the next rising edge
    always @(posedge clk) begin
        if (!rst && q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            vectors++;
            if ({co_h, sum_h} !== it.exp) begin
                miscompares++;
                $display("FAIL %s hybrid a=%h b=%h c=%0d actual=%h expected=%h",
                         it.tag, it.a, it.b, it.c, {co_h, sum_h}, it.exp);
            end
            if ({co_u, sum_u} !== it.exp) begin
                miscompares++;
                $display("FAIL R6 %s homogeneous a=%h b=%h c=%0d actual=%h expected=%h",
                         it.tag, it.a, it.b, it.c, {co_u, sum_u}, it.exp);
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // R8: zero in, zero out
        drive('0, '0, 1'b0, "R8 zero");
        // R5: ripple cells and the 2-bit group
        drive(32'h3, 32'h1, 1'b0, "R5 ripple into low group");
        drive(32'h1, 32'h0, 1'b1, "R5 carry_in through ripple");
        drive(32'h2, 32'h2, 1'b0, "R5 generate at bit1");
        drive(32'h7, 32'h0, 1'b1, "R5 low nibble propagate");
        // R4: group boundary crossings
        drive(32'hF, 32'h1, 1'b0, "R4 nibble to next group");
        drive(32'h0FFF_FFFF, 32'h1, 1'b0, "R4 long chain");
        drive(32'h00F0_0000, 32'h0010_0000, 1'b0, "R4 mid group");
        // R7: full-width carry chains
        drive('1, '0, 1'b1, "R7 all ones plus cin");
        drive('1, '1, 1'b1, "R7 all ones both");
        drive(32'h8000_0000, 32'h8000_0000, 1'b0, "R7 top generate");
        // R2/R3: alternating patterns
        drive(32'hAAAA_AAAA, 32'h5555_5555, 1'b0, "R2 alternating no cin");
        drive(32'hAAAA_AAAA, 32'h5555_5555, 1'b1, "R3 alternating with cin");
        drive(32'hAAAA_AAAA, 32'hAAAA_AAAA, 1'b1, "R3 alternating doubled");
        drive(32'h5555_5555, 32'h5555_5555, 1'b0, "R2 alt generate");
        // R1: random vectors
        for (int n = 0; n < 2000; n++) begin
            drive($urandom(), $urandom(), 1'($urandom() & 1), "R1 random");
        end
        repeat (3) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            miscompares++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule